// File: doc/BRIEF.md
# 8x8 Row-Column Two-Dimensional DCT Core

This core computes the two-dimensional discrete cosine transform of 8x8 blocks of signed pixels. It is split into three parts. A one-dimensional eight-point engine first transforms each incoming pixel row. The result is rounded to a 12-bit intermediate word and written into a two-bank transpose memory. When a bank holds a complete block, a second eight-point engine reads it one column at a time and produces the final coefficients. Those coefficients leave through a registered output stage, one beat per cycle.

Both engines multiply by cosine weights quantised to a signed 9-bit fraction. Each sum is rounded to the nearest integer and saturated to the destination width. While one bank is being drained, the other bank fills. The core therefore accepts a new row on every cycle and keeps up with a continuous stream of blocks. Upstream may pause between rows at any point. A pause only shifts the output in time.

Top module: `dct2d_8x8`

## Requirements
- R1: While reset is held and after it is released with no input, `out_valid` is low and `out_row` is all zeros.
- R2: A row is accepted on each rising edge with `in_valid` high. Lane j of `in_row` (bits j*9 to j*9+8, signed two's complement) is the pixel of column j. Eight accepted rows form one block, taken top to bottom.
- R3: Output beat k of a block carries coefficient column k. Lane u (bits u*12 to u*12+11, signed) holds Y[u][k], where Y[u][v] = 1/4 c(u) c(v) sum over i,j of x[i][j] cos((2i+1)u pi/16) cos((2j+1)v pi/16), with c(0)=1/sqrt(2), other c=1, and i the row index.
- R4: Every output lane differs by at most 4 from the ideal value of R3, where the ideal value is clamped to the range -2048..2047.
- R5: Beat 0 of a block is presented from the first rising edge after the edge that accepts the block's eighth row. Beat k follows k cycles later.
- R6: `out_valid` is high for exactly eight consecutive cycles per block, and the beats come in order 0 to 7.
- R7: Blocks sent back to back with `in_valid` held high are all transformed correctly. The output then has no idle cycle between blocks.
- R8: Cycles with `in_valid` low consume no row, whatever `in_row` carries. Blocks whose rows are separated by such cycles produce the same coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row strobe for `in_row` |
| in_row | input | 72 | Eight signed 9-bit pixels, lane j = column j |
| out_valid | output | 1 | Coefficient beat strobe |
| out_row | output | 96 | Eight signed 12-bit coefficients, lane u = vertical frequency u |

## Verification
Extreme flat blocks (all -256, all 255) push the DC term to the edge of the 12-bit range. A design that wraps instead of rounding would report a sign-flipped DC. A checkerboard and a single impulse drive the highest frequencies, where a wrong weight sign or a lane mix-up shows as large errors. Long back-to-back bursts check that the bank swap happens at the right moment; a late swap would overwrite a block that is still being read and corrupt the next output. Random idle cycles carrying garbage on `in_row` are placed between rows, so a row counter that advanced without `in_valid` would shift every later block. Every beat is also timed against the cycle of its block's eighth row, so an added or missing register stage is caught.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;
  localparam int N    = 8;
  localparam int LOGN = $clog2(N);

  // cos(j*pi/16) scaled by 2^16, j = 0..8
  function automatic longint cos16(input int j);
    case (j)
      0: return 65536;
      1: return 64277;
      2: return 60547;
      3: return 54491;
      4: return 46341;
      5: return 36410;
      6: return 25080;
      7: return 12785;
      default: return 0;
    endcase
  endfunction

  // Quantise a 2^16 value to a cw-bit fraction weight: 0.5*cos scaled by 2^cw.
  function automatic int quant(input longint v, input int cw);
    return int'((v * (64'sd1 <<< (cw - 1)) + 64'sd32768) >>> 16);
  endfunction

  // Weight of output frequency n for input sample m.
  function automatic int weight(input int n, input int m, input int cw);
    int a;
    if (n == 0) return quant(cos16(4), cw);
    a = ((2 * m + 1) * n) % 32;
    if (a > 16) a = 32 - a;
    if (a > 8) return -quant(cos16(16 - a), cw);
    return quant(cos16(a), cw);
  endfunction

  // Round half up by 'sh' fraction bits, then clamp to an ow-bit signed range.
  function automatic int round_sat(input longint acc, input int sh, input int ow);
    longint r;
    longint hi;
    r  = (acc + (64'sd1 <<< (sh - 1))) >>> sh;
    hi = (64'sd1 <<< (ow - 1)) - 1;
    if (r > hi) r = hi;
    if (r < -hi - 1) r = -hi - 1;
    return int'(r);
  endfunction
endpackage

// File: rtl/dct8_pass.sv
module dct8_pass
  import dct2d_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int OUT_W = 12,
  parameter int CW    = 9
) (
  input  logic [N*IN_W-1:0]  x_flat,
  output logic [N*OUT_W-1:0] y_flat
);
  function automatic int lane_dot(input logic [N*IN_W-1:0] xv, input int n);
    longint acc;
    acc = 0;
    for (int m = 0; m < N; m++)
      acc += longint'($signed(xv[m*IN_W +: IN_W])) * longint'(weight(n, m, CW));
    return round_sat(acc, CW, OUT_W);
  endfunction

  for (genvar n = 0; n < N; n++) begin : g_lane
    int res;
    always_comb begin
      res = lane_dot(x_flat, n);
      y_flat[n*OUT_W +: OUT_W] = res[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/dct_xpose.sv
module dct_xpose
  import dct2d_pkg::*;
#(
  parameter int W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [N*W-1:0]  wr_data,
  output logic [N*W-1:0]  rd_data,
  output logic            blk_done,
  output logic            rd_act,
  output logic [LOGN-1:0] rd_col,
  output logic [LOGN-1:0] wr_row
);
  localparam logic [LOGN-1:0] LAST = LOGN'(N - 1);

  logic [W-1:0] mem [2][N][N];
  logic         wr_bank;
  logic         rd_bank;

  assign blk_done = wr_en && (wr_row == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_row  <= '0;
      wr_bank <= 1'b0;
      rd_act  <= 1'b0;
      rd_col  <= '0;
      rd_bank <= 1'b0;
    end else begin
      if (wr_en) wr_row <= wr_row + 1'b1;
      if (blk_done) begin
        wr_bank <= ~wr_bank;
        rd_bank <= wr_bank;
        rd_act  <= 1'b1;
        rd_col  <= '0;
      end else if (rd_act) begin
        rd_col <= rd_col + 1'b1;
        if (rd_col == LAST) rd_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int j = 0; j < N; j++)
        mem[wr_bank][wr_row][j] <= wr_data[j*W +: W];
  end

  for (genvar i = 0; i < N; i++) begin : g_rd
    assign rd_data[i*W +: W] = mem[rd_bank][i][rd_col];
  end
endmodule

// File: rtl/dct2d_8x8.sv
module dct2d_8x8
  import dct2d_pkg::*;
#(
  parameter int PIX_W = 9,
  parameter int MID_W = 12,
  parameter int OUT_W = 12,
  parameter int CW    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [N*PIX_W-1:0]   in_row,
  output logic                 out_valid,
  output logic [N*OUT_W-1:0]   out_row
);
  logic [N*MID_W-1:0] row_res;
  logic [N*MID_W-1:0] col_vec;
  logic [N*OUT_W-1:0] col_res;
  logic               blk_done;
  logic               rd_act;
  logic [LOGN-1:0]    rd_col;
  logic [LOGN-1:0]    wr_row;

  dct8_pass #(.IN_W(PIX_W), .OUT_W(MID_W), .CW(CW)) u_row (
    .x_flat(in_row), .y_flat(row_res)
  );

  dct_xpose #(.W(MID_W)) u_xp (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(row_res),
    .rd_data(col_vec), .blk_done(blk_done), .rd_act(rd_act),
    .rd_col(rd_col), .wr_row(wr_row)
  );

  dct8_pass #(.IN_W(MID_W), .OUT_W(OUT_W), .CW(CW)) u_col (
    .x_flat(col_vec), .y_flat(col_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
    end else begin
      out_valid <= rd_act;
      if (rd_act) out_row <= col_res;
    end
  end
endmodule

// File: rtl/dct2d_8x8_chk.sv
module dct2d_8x8_chk
  import dct2d_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic            blk_done,
  input logic            rd_act,
  input logic [LOGN-1:0] rd_col,
  input logic [LOGN-1:0] wr_row
);
  localparam logic [LOGN-1:0] LAST = LOGN'(N - 1);
  logic [LOGN-1:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_cnt <= '0;
    else if (out_valid) beat_cnt <= beat_cnt + 1'b1;
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wr_row)); // R8
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> ##2 out_valid); // R5
  AST_READ_START: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (rd_act && rd_col == '0)); // R5
  AST_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat_cnt != LAST) |=> out_valid); // R6
  AST_BURST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> beat_cnt == '0); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (!rd_act || rd_col == LAST)); // R7
endmodule

bind dct2d_8x8 dct2d_8x8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .blk_done(blk_done), .rd_act(rd_act), .rd_col(rd_col), .wr_row(wr_row)
);

// File: tb/dct2d_8x8_tb.sv
`timescale 1ns/1ps
module dct2d_8x8_tb;
  localparam int PW = 9;
  localparam int OW = 12;
  localparam real PI = 3.14159265358979;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [8*PW-1:0] in_row;
  logic          out_valid;
  logic [8*OW-1:0] out_row;

  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  int  mb = 0;
  real maxerr = 0.0;
  real exp_q[$];
  int  start_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dct2d_8x8 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row),
    .out_valid(out_valid), .out_row(out_row)
  );

  function automatic real ideal(input int px[64], input int u, input int v);
    real s, cu, cv;
    s = 0.0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        s += px[i*8+j] * $cos((2*i+1)*u*PI/16.0) * $cos((2*j+1)*v*PI/16.0);
    cu = (u == 0) ? 1.0/$sqrt(2.0) : 1.0;
    cv = (v == 0) ? 1.0/$sqrt(2.0) : 1.0;
    s = 0.25 * cu * cv * s;
    if (s > 2047.0) s = 2047.0;
    if (s < -2048.0) s = -2048.0;
    return s;
  endfunction

  task automatic push_expect(input int px[64], input int start);
    for (int k = 0; k < 8; k++)
      for (int u = 0; u < 8; u++)
        exp_q.push_back(ideal(px, u, k));
    start_q.push_back(start);
  endtask

  task automatic send_block(input int px[64], input bit gaps);
    for (int r = 0; r < 8; r++) begin
      if (gaps) begin
        int n;
        n = $urandom_range(0, 2);
        repeat (n) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_row = {$urandom, $urandom, $urandom};
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      for (int j = 0; j < 8; j++) in_row[j*PW +: PW] = PW'(px[r*8+j]);
      if (r == 7) push_expect(px, cyc + 2);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      checks++;
      if (start_q.size() == 0) begin
        fails++;
        $display("FAIL R6: unexpected beat got out_valid=1 expected 0 at cycle %0d", cyc);
      end else begin
        real worst, wexp, e, d;
        int  wgot, got;
        if (cyc != start_q[0] + mb) begin
          fails++;
          $display("FAIL R5,R7: beat %0d at cycle %0d expected cycle %0d", mb, cyc, start_q[0] + mb);
        end
        worst = 0.0; wexp = 0.0; wgot = 0;
        for (int u = 0; u < 8; u++) begin
          got = $signed(out_row[u*OW +: OW]);
          e = exp_q.pop_front();
          d = (got > e) ? got - e : e - got;
          if (d >= worst) begin worst = d; wexp = e; wgot = got; end
        end
        if (worst > maxerr) maxerr = worst;
        checks++;
        if (worst > 4.0) begin
          fails++;
          $display("FAIL R2,R3,R4: beat %0d lane value got %0d expected %f", mb, wgot, wexp);
        end
        mb++;
        if (mb == 8) begin mb = 0; void'(start_q.pop_front()); end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int px[64];
    void'($urandom(32'h5A17));
    rst_n = 1'b0; in_valid = 1'b0; in_row = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_row !== '0) begin
      fails++;
      $display("FAIL R1: got valid=%b row=%h expected 0", out_valid, out_row);
    end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if (out_valid !== 1'b0 || out_row !== '0) begin
      fails++;
      $display("FAIL R1: after release got valid=%b row=%h expected 0", out_valid, out_row);
    end

    // directed corner blocks, back to back (R7)
    foreach (px[i]) px[i] = 0;
    send_block(px, 1'b0);
    foreach (px[i]) px[i] = -256;
    send_block(px, 1'b0);
    foreach (px[i]) px[i] = 255;
    send_block(px, 1'b0);
    foreach (px[i]) px[i] = (((i/8) + (i%8)) % 2) ? -256 : 255;
    send_block(px, 1'b0);
    foreach (px[i]) px[i] = (i == 27) ? 200 : 0;
    send_block(px, 1'b0);
    foreach (px[i]) px[i] = (i%8)*30 - (i/8)*32;
    send_block(px, 1'b0);
    idle(12);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R6: idle got out_valid=%b expected 0", out_valid);
    end

    // random blocks, continuous stream (R7)
    for (int b = 0; b < 12; b++) begin
      foreach (px[i]) px[i] = int'($urandom_range(0, 511)) - 256;
      send_block(px, 1'b0);
    end
    idle(4);
    // random blocks with idle gaps carrying garbage (R8)
    for (int b = 0; b < 10; b++) begin
      foreach (px[i]) px[i] = int'($urandom_range(0, 511)) - 256;
      send_block(px, 1'b1);
    end
    idle(20);

    checks++;
    if (start_q.size() != 0 || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6: got %0d blocks pending expected 0", start_q.size());
    end
    $display("max coefficient error %f", maxerr);
    summary();
  end
endmodule